// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Gating

This block is a free-running watchdog that software must service at intervals shorter than a programmed timeout. Each counted tick advances an internal counter. If the counter reaches the timeout length, the block raises a one-cycle reset request. Writing an unexpected value to the service register also raises a reset request at once.

The counter is not clocked directly by its three possible sources. It runs on the system clock and advances on single-cycle tick enables. The tick enables come from an internal RC source, a crystal oscillator source and an auxiliary source, and two select bits choose one of them. A gating stage looks at the current low-power mode, the select bits and a peripheral clock-enable bit. From these it decides whether the counter advances or holds its value.

Configuration and servicing share one plain write strobe. The strobe is always accepted, so there is no back-pressure. The mode input and the request output are plain level and pulse pins.

Top module: `wdt_stopgate`

## Requirements
- R1: The write data of a configuration write (`wr_addr`=0) holds the fields rate = bits [2:0], select0 = bit 3, select1 = bit 4 and clock-enable = bit 5. The select bits choose the tick source: select1=1 gives `src_tick[2]` (auxiliary), select1=0 with select0=1 gives `src_tick[1]` (oscillator), and select1=0 with select0=0 gives `src_tick[0]` (internal RC). Ticks on the other two sources have no effect.
- R2: In run mode (`mode`=2'b00) the counter advances on every selected tick while the watchdog is enabled, whatever the select bits and clock-enable.
- R3: In pseudo stop (`mode`=2'b01) the counter advances only if select1=1, or if select0=1 and clock-enable=1. Otherwise it holds its value.
- R4: In full stop (`mode`=2'b10, and 2'b11 is treated the same) the counter advances only if select1=1. Otherwise it holds its value.
- R5: With a rate r from 1 to 7, the 2^(BASE_LOG+STEP_LOG*r)-th counted tick since the last clear makes `rst_req` high in the cycle after that tick. The counter then restarts from zero.
- R6: A rate of 0 disables the watchdog. Nothing is counted, no request is raised, and service writes are ignored.
- R7: Servicing (`wr_addr`=1) needs a write of 0x55 followed by a write of 0xAA, and this clears the counter. Repeated 0x55 writes keep the sequence armed. A write of 0xAA that is not armed is ignored.
- R8: While enabled, any service write other than 0x55 or 0xAA raises `rst_req` in the cycle after the write and disarms the sequence.
- R9: `rst_req` is high for exactly one cycle. A request that arises while it is high merges into that pulse.
- R10: A configuration write clears both the counter and the armed state of the service sequence.
- R11: After reset the watchdog is disabled (rate 0), the counter is zero and `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Tick enables: [0] internal RC, [1] oscillator, [2] auxiliary |
| mode | input | 2 | Power mode: 00 run, 01 pseudo stop, 10/11 full stop |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 1 | 0 configuration, 1 service |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume the following about the inputs:
- A tick enable lasts one cycle per source event.
- `mode` only changes between ticks.
- Writes arrive at most one per cycle.

The gating properties hold the counter stable whenever the mode and select inputs forbid counting, unless a clear is in progress. The stimulus drives ticks, mode changes and writes on the falling edge. Each tick is followed by an idle cycle, so every counted edge sees steady mode and configuration. Only one deliberate back-to-back pair of bad service writes is used, to probe how requests merge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int RATE_W = 3;
  localparam int DATA_W = 8;
  localparam int SRC_N  = 3;
  localparam int RATE_MAX = (1 << RATE_W) - 1;

  localparam int SRC_IRC = 0;
  localparam int SRC_OSC = 1;
  localparam int SRC_AUX = 2;

  localparam logic [DATA_W-1:0] SVC_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] SVC_FIRE = 8'hAA;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_PSTOP = 2'b01,
    PM_FSTOP = 2'b10,
    PM_FSTOP_ALT = 2'b11
  } pmode_e;

  // packed MSB first: clk_en is bit 5, rate is bits 2:0
  typedef struct packed {
    logic              clk_en;
    logic              sel1;
    logic              sel0;
    logic [RATE_W-1:0] rate;
  } wdt_cfg_t;

  localparam int CFG_W = $bits(wdt_cfg_t);

  function automatic int unsigned pick_source(input logic sel1, input logic sel0);
    if (sel1)      return SRC_AUX;
    else if (sel0) return SRC_OSC;
    else           return SRC_IRC;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg,
  output logic              cfg_load,
  output logic              svc_ok,
  output logic              svc_bad
);

  wdt_cfg_t cfg_q;
  logic     armed_q;
  logic     enabled;
  logic     svc_hit;
  logic     is_arm;
  logic     is_fire;

  assign enabled  = (cfg_q.rate != '0);
  assign cfg_load = wr_en && (wr_addr == 1'b0);
  assign svc_hit  = wr_en && (wr_addr == 1'b1) && enabled;
  assign is_arm   = (wr_data == SVC_ARM);
  assign is_fire  = (wr_data == SVC_FIRE);

  assign svc_ok  = svc_hit && is_fire && armed_q;
  assign svc_bad = svc_hit && !is_fire && !is_arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_load) begin
      cfg_q <= wdt_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  // arming survives only 0x55 writes; anything else on the service port disarms
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (cfg_load) begin
      armed_q <= 1'b0;
    end else if (svc_hit) begin
      armed_q <= is_arm;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  logic [1:0]       mode,
  input  wdt_cfg_t         cfg,
  input  logic [SRC_N-1:0] src_tick,
  output logic             run_en,
  output logic             step
);

  logic [SRC_N-1:0] src_sel;
  logic             enabled;
  logic             mode_ok;
  int unsigned      pick;

  assign pick    = pick_source(cfg.sel1, cfg.sel0);
  assign enabled = (cfg.rate != '0);

  for (genvar g = 0; g < SRC_N; g++) begin : g_sel
    assign src_sel[g] = (pick == g);
  end

  always_comb begin
    unique case (pmode_e'(mode))
      PM_RUN:   mode_ok = 1'b1;
      PM_PSTOP: mode_ok = cfg.sel1 || (cfg.sel0 && cfg.clk_en);
      default:  mode_ok = cfg.sel1;
    endcase
  end

  assign run_en = enabled && mode_ok;
  assign step   = run_en && |(src_sel & src_tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG = 14,
  parameter int STEP_LOG = 2,
  localparam int CNT_W = BASE_LOG + STEP_LOG * RATE_MAX
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              step,
  input  logic              clear,
  output logic [CNT_W-1:0]  count,
  output logic              expire
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] last_val;
  logic [RATE_W-1:0] rate_gap;

  // limit-1 equals all ones shifted down by the unused rate steps
  assign rate_gap = RATE_W'(RATE_MAX) - rate;
  assign last_val = {CNT_W{1'b1}} >> (STEP_LOG * int'(rate_gap));
  assign expire   = step && (count_q == last_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear || expire) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/wdt_stopgate.sv
module wdt_stopgate
  import wdt_pkg::*;
#(
  parameter int BASE_LOG = 14,
  parameter int STEP_LOG = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        src_tick,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req
);

  localparam int CNT_W = BASE_LOG + STEP_LOG * RATE_MAX;

  wdt_cfg_t         cfg;
  logic             cfg_load;
  logic             svc_ok;
  logic             svc_bad;
  logic             run_en;
  logic             step;
  logic             clear;
  logic             expire;
  logic [CNT_W-1:0] count_q;
  logic             req_q;

  wdt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .cfg_load (cfg_load),
    .svc_ok   (svc_ok),
    .svc_bad  (svc_bad)
  );

  wdt_gate u_gate (
    .mode     (mode),
    .cfg      (cfg),
    .src_tick (src_tick),
    .run_en   (run_en),
    .step     (step)
  );

  assign clear = cfg_load || svc_ok;

  wdt_counter #(
    .BASE_LOG (BASE_LOG),
    .STEP_LOG (STEP_LOG)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate   (cfg.rate),
    .step   (step),
    .clear  (clear),
    .count  (count_q),
    .expire (expire)
  );

  // one-cycle request; a cause arriving while high folds into the same pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= (expire || svc_bad) && !req_q;
    end
  end

  assign rst_req = req_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int BASE_LOG = 14,
  parameter int STEP_LOG = 2,
  localparam int CNT_W = BASE_LOG + STEP_LOG * RATE_MAX
)(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [7:0]        wr_data,
  input logic              rst_req,
  input wdt_cfg_t          cfg,
  input logic              clear,
  input logic [CNT_W-1:0]  count
);

  logic [CNT_W:0] count_wide;
  assign count_wide = {1'b0, count};

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_fstop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !cfg.sel1 && !clear) |=> (count == $past(count)));

  p_pstop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b01) && !cfg.sel1 && !(cfg.sel0 && cfg.clk_en) && !clear)
      |=> (count == $past(count)));

  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rate == '0) |=> ((count == '0) && !rst_req));

  p_bad_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && (cfg.rate != '0) && (wr_data != 8'h55) &&
     (wr_data != 8'hAA) && !rst_req) |=> rst_req);

  p_cfg_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr) |=> (count == '0));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rate != '0) |-> ((count_wide >> (BASE_LOG + STEP_LOG * int'(cfg.rate))) == '0));

endmodule

bind wdt_stopgate wdt_checker #(
  .BASE_LOG (BASE_LOG),
  .STEP_LOG (STEP_LOG)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rst_req (rst_req),
  .cfg     (cfg),
  .clear   (clear),
  .count   (count_q)
);

// File: tb/test_wdt_stopgate.sv
`timescale 1ns/1ps
module test_wdt_stopgate;

  localparam int BL = 2;
  localparam int SL = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src_tick = '0;
  logic [1:0] mode = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rst_req;

  int checks = 0;
  int fails = 0;
  int req_cnt = 0;
  int double_hi = 0;
  logic prev_req = 1'b0;

  always #10 clk = ~clk;

  wdt_stopgate #(.BASE_LOG(BL), .STEP_LOG(SL)) i_wdt_stopgate (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .mode(mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
  );

  always @(negedge clk) begin
    if (rst_n && rst_req) req_cnt++;
    if (rst_n && rst_req && prev_req) double_hi++;
    prev_req = rst_req;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input int rate, input bit s0, input bit s1, input bit ce);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0;
    wr_data = {2'b00, ce, s1, s0, 3'(rate)};
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic svc_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_tick[src] = 1'b1;
      @(negedge clk);
      src_tick = '0;
    end
    #1;
  endtask

  function automatic int src_of(input bit s0, input bit s1);
    if (s1) return 2;
    if (s0) return 1;
    return 0;
  endfunction

  function automatic bit runs(input int m, input bit s0, input bit s1, input bit ce);
    if (m == 0) return 1'b1;
    if (m == 1) return s1 || (s0 && ce);
    return s1;
  endfunction

  function automatic int limit_of(input int r);
    return 1 << (BL + SL * r);
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 rst_req low after reset", int'(rst_req), 0);
    base = req_cnt;
    pulse(0, 40); pulse(1, 40); pulse(2, 40);
    // R6: disabled by default and by rate 0
    chk("R11/R6 no request while disabled after reset", req_cnt - base, 0);
    svc_write(8'h12);
    chk("R6 bad service write ignored when disabled", req_cnt - base, 0);

    // R1..R4: gating sweep at rate 1 (limit 8)
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int ce = 0; ce < 2; ce++) begin
          bit s0 = s[0];
          bit s1 = s[1];
          int sel = src_of(s0, s1);
          cfg_write(1, s0, s1, ce[0]);
          @(negedge clk); mode = 2'(m);
          base = req_cnt;
          for (int o = 0; o < 3; o++) if (o != sel) pulse(o, 8);
          pulse(sel, limit_of(1));
          chk($sformatf("R1/R2/R3/R4 gate mode=%0d sel=%0d ce=%0d", m, s, ce),
              req_cnt - base, runs(m, s0, s1, ce[0]) ? 1 : 0);
          @(negedge clk); mode = 2'b00;
        end
      end
    end

    // R4: value held through full stop
    cfg_write(1, 1'b0, 1'b0, 1'b0);
    base = req_cnt;
    pulse(0, 3);
    @(negedge clk); mode = 2'b10;
    pulse(0, 20);
    @(negedge clk); mode = 2'b00;
    pulse(0, 4);
    chk("R4 counter held in full stop, no early request", req_cnt - base, 0);
    pulse(0, 1);
    chk("R4 count resumes from held value", req_cnt - base, 1);

    // R3: value held through pseudo stop
    cfg_write(1, 1'b1, 1'b0, 1'b0);
    base = req_cnt;
    pulse(1, 5);
    @(negedge clk); mode = 2'b01;
    pulse(1, 20);
    @(negedge clk); mode = 2'b00;
    pulse(1, 2);
    chk("R3 counter held in pseudo stop", req_cnt - base, 0);
    pulse(1, 1);
    chk("R3 count resumes after pseudo stop", req_cnt - base, 1);

    // R5: timeout length per rate
    for (int r = 1; r < 8; r++) begin
      cfg_write(r, 1'b0, 1'b1, 1'b0);
      base = req_cnt;
      pulse(2, limit_of(r) - 1);
      chk($sformatf("R5 no request one tick early rate=%0d", r), req_cnt - base, 0);
      pulse(2, 1);
      chk($sformatf("R5 request at timeout rate=%0d", r), req_cnt - base, 1);
      if (r == 1) begin
        pulse(2, limit_of(r) - 1);
        chk("R5 counter restarts after timeout", req_cnt - base, 1);
        pulse(2, 1);
        chk("R5 second timeout after restart", req_cnt - base, 2);
      end
    end

    // R7: service sequence
    cfg_write(2, 1'b0, 1'b0, 1'b0);
    base = req_cnt;
    pulse(0, 15);
    svc_write(8'h55); svc_write(8'hAA);
    pulse(0, 15);
    chk("R7 service clears counter", req_cnt - base, 0);
    pulse(0, 1);
    chk("R7 timeout after serviced period", req_cnt - base, 1);
    pulse(0, 10);
    svc_write(8'h55); svc_write(8'h55); svc_write(8'hAA);
    pulse(0, 15);
    chk("R7 repeated 0x55 keeps arming", req_cnt - base, 1);
    pulse(0, 1);
    chk("R7 timeout after double-arm service", req_cnt - base, 2);
    cfg_write(2, 1'b0, 1'b0, 1'b0);
    base = req_cnt;
    pulse(0, 15);
    svc_write(8'hAA);
    pulse(0, 1);
    chk("R7 unarmed 0xAA ignored", req_cnt - base, 1);

    // R10: configuration write disarms
    cfg_write(2, 1'b0, 1'b0, 1'b0);
    base = req_cnt;
    svc_write(8'h55);
    cfg_write(2, 1'b0, 1'b0, 1'b0);
    pulse(0, 15);
    svc_write(8'hAA);
    pulse(0, 1);
    chk("R10 config write drops arming", req_cnt - base, 1);
    pulse(0, 9);
    cfg_write(2, 1'b0, 1'b0, 1'b0);
    pulse(0, 15);
    chk("R10 config write clears counter", req_cnt - base, 1);

    // R8: bad service value
    base = req_cnt;
    svc_write(8'h12);
    chk("R8 bad service write requests reset", req_cnt - base, 1);
    svc_write(8'h55);
    svc_write(8'h00);
    chk("R8 bad write after arm requests reset", req_cnt - base, 2);

    // R9: merged back-to-back requests
    base = req_cnt;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h12;
    @(negedge clk);
    wr_data = 8'h34;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 adjacent causes merge into one pulse", req_cnt - base, 1);
    chk("R9 request never high two cycles", double_hi, 0);

    // R6: rate 0 stops counting
    cfg_write(0, 1'b0, 1'b1, 1'b1);
    base = req_cnt;
    pulse(2, 600);
    chk("R6 rate 0 disables counting", req_cnt - base, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule